// File: doc/BRIEF.md
# Fully Associative Write-Through Cache

This block sits between a processor-side word port and a slower main-memory port. It holds a small number of single-word lines. Each line keeps the complete word address as its tag, a valid flag and one data word. A lookup uses no index bits. The incoming address is compared against every valid tag at the same time, so any address can occupy any line.

Read hits are answered from the cache without touching main memory. A read miss fetches the word and installs it in a chosen line. Every write is forwarded to main memory. A write that hits updates the line in place, and a write that misses allocates a line holding the new value. Two saturating counters record hits and misses so that the hit ratio of a workload can be measured. For example, a 4-cycle cache in front of a 40-cycle memory needs 97.5% hits for a 5-cycle average access time.

The controller is a three-state machine:
- `ST_IDLE` accepts requests.
- `ST_FILL` waits for a read-miss word.
- `ST_WRITE` waits for a forwarded write.

It moves between them as follows:
- `ST_IDLE` goes to `ST_WRITE` on any accepted write.
- `ST_IDLE` goes to `ST_FILL` on an accepted read miss.
- `ST_IDLE` stays put on a read hit.
- `ST_FILL` and `ST_WRITE` return to `ST_IDLE` in the cycle `mem_done` is sampled.

Top module: `fa_wt_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` is 1, both counters are 0, and `cpu_rvalid` and `mem_req` are 0; the first access to any address is therefore a miss.
- R2: A read accepted (`cpu_req` and `cpu_ready` high) whose address matches a valid tag raises `cpu_rvalid` for one cycle in the next cycle with that line's data, issues no main-memory request and adds 1 to `hit_count`.
- R3: An accepted read with no match issues one main-memory read (`mem_we`=0) of that address and adds 1 to `miss_count`. When `mem_done` is sampled, the returned word is presented with `cpu_rvalid` in the next cycle and installed, so a repeat read of that address hits.
- R4: An accepted write that hits replaces the line's data and issues one main-memory write (`mem_we`=1) of the same address and value; a later read hit returns the new value.
- R5: An accepted write that misses issues one main-memory write and allocates a line whose tag is the address and whose data is the written value; a later read of that address hits.
- R6: A fill or write-miss allocation takes the lowest-numbered invalid line if one exists. Otherwise it takes the line named by a round-robin pointer that starts at line 0 after reset and advances by one, modulo the line count, on every allocation.
- R7: `cpu_ready` is 0 from the cycle after any write or read miss is accepted until the cycle after `mem_done` is sampled, when it returns to 1.
- R8: `hit_count` and `miss_count` each count by one per classified access and hold at all ones instead of wrapping.
- R9: `cnt_clear` sampled high sets both counters to 0 on that edge, taking priority over any increment in the same cycle.
- R10: `mem_req` is a one-cycle pulse, with `mem_addr`, `mem_we` and `mem_wdata` valid alongside it, and no new request is issued until `mem_done` for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | Cache can accept a request this cycle |
| cpu_rvalid | output | 1 | Read data valid pulse |
| cpu_rdata | output | DW | Read data |
| mem_req | output | 1 | Main-memory request pulse |
| mem_we | output | 1 | Main-memory request is a write |
| mem_addr | output | AW | Main-memory word address |
| mem_wdata | output | DW | Main-memory write data |
| mem_done | input | 1 | Main-memory completion pulse |
| mem_rdata | input | DW | Main-memory read data, valid with mem_done |
| cnt_clear | input | 1 | Synchronous clear of both counters |
| hit_count | output | CNT_W | Saturating hit count |
| miss_count | output | CNT_W | Saturating miss count |

## Verification
The bench first fills every line. It then makes a read miss evict the round-robin victim and re-reads the evicted address. A design that picked a victim other than the invalid-first, round-robin line would report a hit where a miss is due, or return stale data.

Writes are mixed into a long pseudo-random sweep over a pool of addresses twice the line count. At the end, main memory is compared against an independently kept image. A design that dropped the forwarding of write hits, or skipped allocation on write misses, shows up as wrong memory contents or wrong hit counts.

Hit counting is pushed past its saturation limit and then cleared in the same cycle as an access. This catches counters that wrap, or that let the increment win over the clear.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } cache_state_e;
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
    parameter int LINES = 8,
    parameter int AW    = 16,
    localparam int IDXW = $clog2(LINES)
) (
    input  logic [LINES-1:0][AW-1:0] tags,
    input  logic [LINES-1:0]         valid,
    input  logic [AW-1:0]            addr,
    output logic                     hit,
    output logic [IDXW-1:0]          hit_idx
);
    logic [LINES-1:0] match;

    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == addr);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (match[i]) hit_idx = hit_idx | IDXW'(i);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/fa_victim_sel.sv
module fa_victim_sel #(
    parameter int LINES = 8,
    localparam int IDXW = $clog2(LINES)
) (
    input  logic [LINES-1:0] valid,
    input  logic [IDXW-1:0]  rr_ptr,
    output logic [IDXW-1:0]  victim
);
    always_comb begin
        victim = rr_ptr;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (!valid[i]) victim = IDXW'(i);
        end
    end
endmodule

// File: rtl/fa_sat_counter.sv
module fa_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (inc && !(&count)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/fa_wt_cache.sv
module fa_wt_cache
    import fa_cache_pkg::*;
#(
    parameter int LINES = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [DW-1:0]    cpu_wdata,
    output logic             cpu_ready,
    output logic             cpu_rvalid,
    output logic [DW-1:0]    cpu_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_done,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             cnt_clear,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    localparam int IDXW = $clog2(LINES);
    localparam logic [IDXW-1:0] LAST_LINE = IDXW'(LINES - 1);

    cache_state_e state_q, state_d;

    logic [LINES-1:0][AW-1:0] tags_q;
    logic [LINES-1:0][DW-1:0] data_q;
    logic [LINES-1:0]         valid_q;
    logic [IDXW-1:0]          rr_q;
    logic [IDXW-1:0]          victim, victim_q, hit_idx;
    logic                     lookup_hit, accept;
    logic [AW-1:0]            req_addr_q;
    logic [DW-1:0]            req_wdata_q;
    logic                     req_we_q, mem_req_q, rvalid_q;
    logic [DW-1:0]            rdata_q;

    fa_tag_match #(.LINES(LINES), .AW(AW)) match_i (
        .tags(tags_q), .valid(valid_q), .addr(cpu_addr),
        .hit(lookup_hit), .hit_idx(hit_idx)
    );

    fa_victim_sel #(.LINES(LINES)) victim_i (
        .valid(valid_q), .rr_ptr(rr_q), .victim(victim)
    );

    fa_sat_counter #(.W(CNT_W)) hit_ctr_i (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear),
        .inc(accept && lookup_hit), .count(hit_count)
    );

    fa_sat_counter #(.W(CNT_W)) miss_ctr_i (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear),
        .inc(accept && !lookup_hit), .count(miss_count)
    );

    assign cpu_ready = (state_q == ST_IDLE);
    assign accept    = cpu_req && cpu_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && cpu_we)           state_d = ST_WRITE;
                else if (accept && !lookup_hit) state_d = ST_FILL;
            end
            ST_FILL:  if (mem_done) state_d = ST_IDLE;
            ST_WRITE: if (mem_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // arrays and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tags_q      <= '0;
            data_q      <= '0;
            valid_q     <= '0;
            rr_q        <= '0;
            victim_q    <= '0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            req_we_q    <= 1'b0;
            mem_req_q   <= 1'b0;
            rvalid_q    <= 1'b0;
            rdata_q     <= '0;
        end else begin
            mem_req_q <= 1'b0;
            rvalid_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        req_addr_q  <= cpu_addr;
                        req_wdata_q <= cpu_wdata;
                        req_we_q    <= cpu_we;
                        victim_q    <= victim;
                        if (cpu_we) begin
                            mem_req_q <= 1'b1;
                            if (lookup_hit) begin
                                data_q[hit_idx] <= cpu_wdata;
                            end else begin
                                tags_q[victim]  <= cpu_addr;
                                data_q[victim]  <= cpu_wdata;
                                valid_q[victim] <= 1'b1;
                                rr_q <= (rr_q == LAST_LINE) ? '0 : rr_q + 1'b1;
                            end
                        end else if (lookup_hit) begin
                            rdata_q  <= data_q[hit_idx];
                            rvalid_q <= 1'b1;
                        end else begin
                            mem_req_q <= 1'b1;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_done) begin
                        tags_q[victim_q]  <= req_addr_q;
                        data_q[victim_q]  <= mem_rdata;
                        valid_q[victim_q] <= 1'b1;
                        rr_q     <= (rr_q == LAST_LINE) ? '0 : rr_q + 1'b1;
                        rdata_q  <= mem_rdata;
                        rvalid_q <= 1'b1;
                    end
                end
                ST_WRITE: ;
                default: ;
            endcase
        end
    end

    assign cpu_rvalid = rvalid_q;
    assign cpu_rdata  = rdata_q;
    assign mem_req    = mem_req_q;
    assign mem_we     = req_we_q;
    assign mem_addr   = req_addr_q;
    assign mem_wdata  = req_wdata_q;
endmodule

// File: rtl/fa_wt_cache_chk.sv
module fa_wt_cache_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_req,
    input logic             cpu_we,
    input logic             cpu_ready,
    input logic             cpu_rvalid,
    input logic             lookup_hit,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_done,
    input logic             cnt_clear,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count
);
    // R2
    read_hit_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && !cpu_we && lookup_hit) |=> (cpu_rvalid && !mem_req));

    // R3
    miss_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && !lookup_hit) |=> mem_req);

    // R4
    write_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && cpu_we) |=> (mem_req && mem_we));

    // R7
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    // R7
    done_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ready && mem_done) |=> cpu_ready);

    // R8
    hit_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&hit_count) && !cnt_clear) |=> (&hit_count));

    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> (hit_count == '0 && miss_count == '0));

    // R10
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
endmodule

bind fa_wt_cache fa_wt_cache_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .lookup_hit(lookup_hit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_done(mem_done),
    .cnt_clear(cnt_clear), .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/fa_wt_cache_tb.sv
module fa_wt_cache_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LINES   = 4;
    localparam int AW      = 8;
    localparam int DW      = 16;
    localparam int CNT_W   = 6;
    localparam int MEM_LAT = 3;
    localparam int DEPTH   = 1 << AW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0]    cpu_addr = '0;
    logic [DW-1:0]    cpu_wdata = '0;
    logic             cpu_ready, cpu_rvalid;
    logic [DW-1:0]    cpu_rdata;
    logic             mem_req, mem_we;
    logic [AW-1:0]    mem_addr;
    logic [DW-1:0]    mem_wdata;
    logic             mem_done = 1'b0;
    logic [DW-1:0]    mem_rdata = '0;
    logic             cnt_clear = 1'b0;
    logic [CNT_W-1:0] hit_count, miss_count;

    int tests = 0, fails = 0;
    int mem_rd_cnt = 0, mem_wr_cnt = 0, proto_err = 0;
    bit finished = 0;

    logic [DW-1:0] mem_arr [DEPTH];
    logic [DW-1:0] exp_mem [DEPTH];
    logic [AW-1:0] m_tag [LINES];
    bit            m_val [LINES];
    int            m_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    fa_wt_cache #(.LINES(LINES), .AW(AW), .DW(DW), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_done(mem_done), .mem_rdata(mem_rdata), .cnt_clear(cnt_clear),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    function automatic logic [DW-1:0] init_word(input int a);
        return DW'(a * 37 + 5);
    endfunction

    // main-memory model: fixed latency, done pulse
    initial begin
        int cnt = 0;
        bit busy = 0;
        logic [AW-1:0] a_q = '0;
        for (int i = 0; i < DEPTH; i++) mem_arr[i] = init_word(i);
        forever begin
            @(negedge clk);
            if (busy) begin
                if (mem_req) proto_err++;
                cnt--;
                if (cnt == 0) begin
                    mem_done  = 1'b1;
                    mem_rdata = mem_arr[a_q];
                    busy = 0;
                end
            end else begin
                mem_done = 1'b0;
                if (mem_req) begin
                    busy = 1;
                    cnt  = MEM_LAT;
                    a_q  = mem_addr;
                    if (mem_we) begin
                        mem_arr[mem_addr] = mem_wdata;
                        mem_wr_cnt++;
                    end else begin
                        mem_rd_cnt++;
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < LINES; i++) begin
            m_val[i] = 0;
            m_tag[i] = '0;
        end
        m_ptr = 0;
    endtask

    // predicts hit, allocates on miss; returns the line used
    task automatic model_access(input logic [AW-1:0] a, output bit hit, output int line);
        hit = 0;
        line = -1;
        for (int i = 0; i < LINES; i++) begin
            if (m_val[i] && m_tag[i] == a) begin
                hit = 1;
                line = i;
            end
        end
        if (!hit) begin
            line = m_ptr;
            for (int i = LINES - 1; i >= 0; i--) if (!m_val[i]) line = i;
            m_tag[line] = a;
            m_val[line] = 1;
            m_ptr = (m_ptr + 1) % LINES;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cpu_req = 1'b0;
        cnt_clear = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic clear_counts();
        @(negedge clk);
        cnt_clear = 1'b1;
        @(negedge clk);
        cnt_clear = 1'b0;
    endtask

    // one access; ready_after is cpu_ready at the first negedge after acceptance
    task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] rd, output logic ready_after);
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b1;
        cpu_we = we;
        cpu_addr = a;
        cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0;
        ready_after = cpu_ready;
        rd = '0;
        if (!we) begin
            while (!cpu_rvalid) @(negedge clk);
            rd = cpu_rdata;
        end
        while (!cpu_ready) @(negedge clk);
        if (we) exp_mem[a] = d;
    endtask

    // checked access against the bench model
    task automatic checked(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
        logic [DW-1:0] rd;
        logic rdy;
        bit hit;
        int line;
        int rd0, wr0;
        rd0 = mem_rd_cnt;
        wr0 = mem_wr_cnt;
        model_access(a, hit, line);
        clear_counts();
        access(we, a, d, rd, rdy);
        chk({req, " hit_count"}, 32'(hit_count), hit ? 1 : 0);
        chk({req, " miss_count"}, 32'(miss_count), hit ? 0 : 1);
        chk({req, " mem writes"}, 32'(mem_wr_cnt - wr0), we ? 1 : 0);
        chk({req, " mem reads"}, 32'(mem_rd_cnt - rd0), (!we && !hit) ? 1 : 0);
        if (!we) chk({req, " rdata"}, 32'(rd), 32'(exp_mem[a]));
        if (we || !hit) chk({req, " R7 ready low"}, 32'(rdy), 0);
    endtask

    initial begin
        logic [DW-1:0] rd;
        logic rdy;
        logic [31:0] seed = 32'h1234_5678;
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = init_word(i);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ready", 32'(cpu_ready), 1);
        chk("R1 hit_count", 32'(hit_count), 0);
        chk("R1 miss_count", 32'(miss_count), 0);
        chk("R1 rvalid", 32'(cpu_rvalid), 0);
        chk("R1 mem_req", 32'(mem_req), 0);

        // R3 read miss fills, R2 then hits
        checked(1'b0, 8'd10, '0, "R3 read miss");
        checked(1'b0, 8'd10, '0, "R2 read hit");
        // R4 write hit forwarded and visible
        checked(1'b1, 8'd10, 16'hBEEF, "R4 write hit");
        checked(1'b0, 8'd10, '0, "R4 read after write");
        // R5 write miss allocates
        checked(1'b1, 8'd20, 16'h1357, "R5 write miss");
        checked(1'b0, 8'd20, '0, "R5 read allocated");

        // R6 directed replacement from a clean state
        do_reset();
        for (int i = 1; i <= LINES; i++) checked(1'b0, AW'(i), '0, "R6 fill invalid");
        checked(1'b0, 8'd9, '0, "R6 evict rr line0");
        checked(1'b0, 8'd2, '0, "R6 survivor hits");
        checked(1'b0, 8'd1, '0, "R6 evicted misses");
        checked(1'b1, 8'd11, 16'h0A0A, "R6 write miss evicts line2");
        checked(1'b0, 8'd3, '0, "R6 line2 evicted");

        // sweep: mixed traffic over twice the line count of addresses
        do_reset();
        for (int n = 0; n < 400; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            checked(seed[20], AW'(seed[18:16]) + 8'd40, DW'(seed[31:16] ^ 16'(n)),
                    seed[20] ? "R4 R5 sweep write" : "R2 R3 R6 sweep read");
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (mem_arr[i] !== exp_mem[i]) chk("R4 R5 memory image", 32'(mem_arr[i]), 32'(exp_mem[i]));
        end
        chk("R4 R5 memory image ok", 32'(fails == 0), 1);

        // R8 saturation: 70 hits on cached address
        checked(1'b0, 8'd77, '0, "R8 prime");
        clear_counts();
        for (int n = 0; n < 70; n++) access(1'b0, 8'd77, '0, rd, rdy);
        chk("R8 hit saturates", 32'(hit_count), 63);
        chk("R8 miss untouched", 32'(miss_count), 0);
        access(1'b1, 8'd200, 16'h55AA, rd, rdy);
        chk("R8 miss counts", 32'(miss_count), 1);

        // R9 clear in same cycle as a hit
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'd77; cnt_clear = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0; cnt_clear = 1'b0;
        chk("R9 clear wins hit", 32'(hit_count), 0);
        chk("R9 clear miss", 32'(miss_count), 0);
        chk("R9 read still served", 32'(cpu_rdata), 32'(exp_mem[77]));

        // R10 protocol
        chk("R10 no request while busy", 32'(proto_err), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule